// File: doc/BRIEF.md
# Context-Tagged Translation Lookaside Buffer

This block is a small fully associative store of virtual-page to physical-page translations. Each stored translation carries a context tag and a global marker. A requester presents a virtual page number on the lookup port. One clock later the block reports hit or miss and the physical page. After a miss the requester installs the translation through the fill port. The block does no table walk of its own.

A control side models the page-table base register and a tagging enable. With tagging off, every base-register write empties the buffer. With tagging on, the low bits of the written value become the current context, and existing entries survive. A lookup then sees only entries tagged with the current context, plus global entries. A set purge bit in the written value removes the new context's entries. A separate command removes the entries of any named context. A flush-all input clears everything.

Top module: `ctx_tlb`

## Requirements
- R1: `lk_done` rises exactly one clock after a cycle with `lk_valid` high. `lk_hit` and `lk_ppn` are valid in that same cycle. On a miss, or when no lookup was made, `lk_ppn` is zero.
- R2: A non-global entry hits only when its virtual page equals `lk_vpn` and its context tag equals `cur_ctx`. When several entries match, the lowest-numbered one supplies `lk_ppn`.
- R3: An entry filled with `fill_global` = 1 hits on its virtual page under any current context.
- R4: A fill tags the new entry with the `cur_ctx` in force during the fill cycle. In flat mode that context is 0.
- R5: In flat mode (`tag_mode` = 0), a `base_wr` invalidates every entry, global ones included.
- R6: In tagged mode, `base_wr` loads `cur_ctx` from `base_val[11:0]` and keeps all entries valid when `base_val[63]` = 0.
- R7: In tagged mode, `base_wr` with `base_val[63]` = 1 also removes every non-global entry whose tag equals the newly loaded context. Other entries are kept.
- R8: `inv_ctx_req` removes every non-global entry tagged `inv_ctx_id`. Global entries and entries of other contexts are kept.
- R9: `flush_all` invalidates every entry, global ones included. A fill in the same cycle is dropped.
- R10: A fill that matches no entry goes to the lowest-numbered invalid slot. If all 16 slots are valid, it replaces the slot named by a round-robin pointer. The pointer starts at 0 after reset, advances by one (mod 16) only on such an eviction, and is not reset by flushes.
- R11: A fill whose virtual page matches an entry visible in the current context (as in R2/R3) overwrites that entry. The entry takes the new physical page, the new global flag and the current tag, so no duplicate is created.
- R12: After reset the buffer is empty, `tag_mode` = 0 and `cur_ctx` = 0. `mode_wr` sets the mode to `mode_tagged`. Leaving tagged mode sets `cur_ctx` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Write the tagging enable |
| mode_tagged | input | 1 | New tagging enable value |
| base_wr | input | 1 | Write of the page-table base register |
| base_val | input | 64 | Value written; bits 11:0 are the context, bit 63 requests a context purge |
| inv_ctx_req | input | 1 | Invalidate entries of one context |
| inv_ctx_id | input | 12 | Context to invalidate |
| flush_all | input | 1 | Invalidate every entry |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | 20 | Virtual page to install |
| fill_ppn | input | 20 | Physical page to install |
| fill_global | input | 1 | Mark the installed entry global |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page to look up |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup found a translation |
| lk_ppn | output | 20 | Physical page of the hit, zero otherwise |
| cur_ctx | output | 12 | Current context |
| tag_mode | output | 1 | Tagging enable in force |

## Verification
Several properties are checked on every cycle: the one-cycle response timing, a zero page on a miss, an empty buffer after a flush or a flat-mode base write, loading of the context and keeping of entries on a tagged base write, a zero context in flat mode, and non-emptiness after a fill. Which entries are visible to which context, that global entries survive purges, overwrite instead of duplication, and victim order can only be shown through the bench's scenarios. The bench compares lookup results with a reference model of the entry array.

// File: rtl/ctx_tlb_pkg.sv
package ctx_tlb_pkg;
    typedef enum logic [0:0] {
        MODE_FLAT   = 1'b0,
        MODE_TAGGED = 1'b1
    } tlb_mode_e;
endpackage

// File: rtl/ctx_tlb_ctrl.sv
module ctx_tlb_ctrl
    import ctx_tlb_pkg::*;
#(
    parameter int CTX_W     = 12,
    parameter int BASE_W    = 64,
    parameter int FLUSH_BIT = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic              mode_tagged,
    input  logic              base_wr,
    input  logic [BASE_W-1:0] base_val,
    input  logic              inv_ctx_req,
    input  logic [CTX_W-1:0]  inv_ctx_id,
    input  logic              flush_all,
    output tlb_mode_e         mode,
    output logic [CTX_W-1:0]  cur_ctx,
    output logic              clr_all,
    output logic              purge_a_en,
    output logic [CTX_W-1:0]  purge_a_id,
    output logic              purge_b_en,
    output logic [CTX_W-1:0]  purge_b_id
);
    tlb_mode_e        state_q, state_d;
    logic [CTX_W-1:0] ctx_q, ctx_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MODE_FLAT;
            ctx_q   <= '0;
        end else begin
            state_q <= state_d;
            ctx_q   <= ctx_d;
        end
    end

    // transitions: FLAT->TAGGED on enable write, TAGGED->FLAT on disable write
    always_comb begin
        state_d = state_q;
        ctx_d   = ctx_q;
        unique case (state_q)
            MODE_FLAT: begin
                if (mode_wr && mode_tagged) state_d = MODE_TAGGED;
            end
            MODE_TAGGED: begin
                if (base_wr) ctx_d = base_val[CTX_W-1:0];
                if (mode_wr && !mode_tagged) begin
                    state_d = MODE_FLAT;
                    ctx_d   = '0;
                end
            end
        endcase
    end

    // outputs decoded from the current state
    always_comb begin
        mode       = state_q;
        cur_ctx    = ctx_q;
        clr_all    = flush_all;
        purge_a_en = inv_ctx_req;
        purge_a_id = inv_ctx_id;
        purge_b_en = 1'b0;
        purge_b_id = base_val[CTX_W-1:0];
        unique case (state_q)
            MODE_FLAT:   clr_all    = flush_all | base_wr;
            MODE_TAGGED: purge_b_en = base_wr & base_val[FLUSH_BIT];
        endcase
    end
endmodule

// File: rtl/ctx_tlb_match.sv
module ctx_tlb_match #(
    parameter int N     = 16,
    parameter int VPN_W = 20,
    parameter int CTX_W = 12,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]            valid,
    input  logic [N-1:0][VPN_W-1:0] vpn,
    input  logic [N-1:0][CTX_W-1:0] tag,
    input  logic [N-1:0]            glob,
    input  logic [VPN_W-1:0]        key_vpn,
    input  logic [CTX_W-1:0]        key_ctx,
    output logic [N-1:0]            hit,
    output logic                    any,
    output logic [IDX_W-1:0]        idx
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit[g] = valid[g] && (vpn[g] == key_vpn) && (glob[g] || (tag[g] == key_ctx));
    end

    assign any = |hit;

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/ctx_tlb_victim.sv
module ctx_tlb_victim #(
    parameter int N = 16,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     valid,
    input  logic             fill_fire,
    input  logic             match_any,
    input  logic [IDX_W-1:0] match_idx,
    output logic [IDX_W-1:0] sel
);
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             free_any;

    always_comb begin
        free_idx = '0;
        free_any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_idx = IDX_W'(i);
                free_any = 1'b1;
            end
        end
    end

    always_comb begin
        if (match_any)     sel = match_idx;
        else if (free_any) sel = free_idx;
        else               sel = rr_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (fill_fire && !match_any && !free_any) begin
            if (rr_q == IDX_W'(N - 1)) rr_q <= '0;
            else                       rr_q <= rr_q + 1'b1;
        end
    end
endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
    import ctx_tlb_pkg::*;
#(
    parameter int ENTRIES   = 16,
    parameter int VPN_W     = 20,
    parameter int PPN_W     = 20,
    parameter int CTX_W     = 12,
    parameter int BASE_W    = 64,
    parameter int FLUSH_BIT = 63,
    localparam int IDX_W    = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic              mode_tagged,
    input  logic              base_wr,
    input  logic [BASE_W-1:0] base_val,
    input  logic              inv_ctx_req,
    input  logic [CTX_W-1:0]  inv_ctx_id,
    input  logic              flush_all,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic              fill_global,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              lk_done,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic [CTX_W-1:0]  cur_ctx,
    output logic              tag_mode
);
    logic [ENTRIES-1:0]            valid_q;
    logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
    logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
    logic [ENTRIES-1:0][CTX_W-1:0] tag_q;
    logic [ENTRIES-1:0]            glob_q;

    tlb_mode_e        mode;
    logic             clr_all, purge_a_en, purge_b_en;
    logic [CTX_W-1:0] purge_a_id, purge_b_id;

    ctx_tlb_ctrl #(.CTX_W(CTX_W), .BASE_W(BASE_W), .FLUSH_BIT(FLUSH_BIT)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .mode_wr(mode_wr), .mode_tagged(mode_tagged),
        .base_wr(base_wr), .base_val(base_val),
        .inv_ctx_req(inv_ctx_req), .inv_ctx_id(inv_ctx_id),
        .flush_all(flush_all),
        .mode(mode), .cur_ctx(cur_ctx), .clr_all(clr_all),
        .purge_a_en(purge_a_en), .purge_a_id(purge_a_id),
        .purge_b_en(purge_b_en), .purge_b_id(purge_b_id)
    );

    assign tag_mode = (mode == MODE_TAGGED);

    logic [ENTRIES-1:0] lk_hitv, fl_hitv;
    logic               lk_any, fl_any;
    logic [IDX_W-1:0]   lk_idx, fl_idx, fill_sel;

    ctx_tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .CTX_W(CTX_W)) u_lk_match (
        .valid(valid_q), .vpn(vpn_q), .tag(tag_q), .glob(glob_q),
        .key_vpn(lk_vpn), .key_ctx(cur_ctx),
        .hit(lk_hitv), .any(lk_any), .idx(lk_idx)
    );

    ctx_tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .CTX_W(CTX_W)) u_fl_match (
        .valid(valid_q), .vpn(vpn_q), .tag(tag_q), .glob(glob_q),
        .key_vpn(fill_vpn), .key_ctx(cur_ctx),
        .hit(fl_hitv), .any(fl_any), .idx(fl_idx)
    );

    logic fill_fire;
    assign fill_fire = fill_valid && !clr_all;

    ctx_tlb_victim #(.N(ENTRIES)) u_victim (
        .clk(clk), .rst_n(rst_n), .valid(valid_q),
        .fill_fire(fill_fire), .match_any(fl_any), .match_idx(fl_idx),
        .sel(fill_sel)
    );

    logic [ENTRIES-1:0] purge_hit;
    for (genvar g = 0; g < ENTRIES; g++) begin : g_purge
        assign purge_hit[g] = valid_q[g] && !glob_q[g] &&
                              ((purge_a_en && (tag_q[g] == purge_a_id)) ||
                               (purge_b_en && (tag_q[g] == purge_b_id)));
    end

    // entry array
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            vpn_q   <= '0;
            ppn_q   <= '0;
            tag_q   <= '0;
            glob_q  <= '0;
        end else if (clr_all) begin
            valid_q <= '0;
        end else begin
            valid_q <= valid_q & ~purge_hit;
            if (fill_fire) begin
                valid_q[fill_sel] <= 1'b1;
                vpn_q[fill_sel]   <= fill_vpn;
                ppn_q[fill_sel]   <= fill_ppn;
                tag_q[fill_sel]   <= cur_ctx;
                glob_q[fill_sel]  <= fill_global;
            end
        end
    end

    // registered lookup response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_done <= 1'b0;
            lk_hit  <= 1'b0;
            lk_ppn  <= '0;
        end else begin
            lk_done <= lk_valid;
            lk_hit  <= lk_valid && lk_any;
            lk_ppn  <= (lk_valid && lk_any) ? ppn_q[lk_idx] : '0;
        end
    end
endmodule

// File: rtl/ctx_tlb_chk.sv
module ctx_tlb_chk #(
    parameter int ENTRIES   = 16,
    parameter int PPN_W     = 20,
    parameter int CTX_W     = 12,
    parameter int BASE_W    = 64,
    parameter int FLUSH_BIT = 63
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic               lk_done,
    input logic               lk_hit,
    input logic [PPN_W-1:0]   lk_ppn,
    input logic               flush_all,
    input logic               base_wr,
    input logic [BASE_W-1:0]  base_val,
    input logic               mode_wr,
    input logic               fill_valid,
    input logic               inv_ctx_req,
    input logic               tag_mode,
    input logic [CTX_W-1:0]   cur_ctx,
    input logic [ENTRIES-1:0] valid_q
);
    a_r1_done_timing: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> lk_done);
    a_r1_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !lk_done);
    a_r1_miss_ppn_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_ppn == '0));
    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (valid_q == '0));
    a_r5_flat_base_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (base_wr && !tag_mode) |=> (valid_q == '0));
    a_r6_ctx_load: assert property (@(posedge clk) disable iff (!rst_n)
        (base_wr && tag_mode && !mode_wr) |=> (cur_ctx == $past(base_val[CTX_W-1:0])));
    a_r6_entries_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (base_wr && tag_mode && !base_val[FLUSH_BIT] && !mode_wr && !flush_all &&
         !fill_valid && !inv_ctx_req)
        |=> ($countones(valid_q) == $countones($past(valid_q))));
    a_r12_flat_ctx_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !tag_mode |-> (cur_ctx == '0));
    a_r4_fill_occupies: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !flush_all && !(base_wr && !tag_mode)) |=> (valid_q != '0));
endmodule

bind ctx_tlb ctx_tlb_chk #(
    .ENTRIES(ENTRIES), .PPN_W(PPN_W), .CTX_W(CTX_W),
    .BASE_W(BASE_W), .FLUSH_BIT(FLUSH_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_done(lk_done),
    .lk_hit(lk_hit), .lk_ppn(lk_ppn), .flush_all(flush_all),
    .base_wr(base_wr), .base_val(base_val), .mode_wr(mode_wr),
    .fill_valid(fill_valid), .inv_ctx_req(inv_ctx_req),
    .tag_mode(tag_mode), .cur_ctx(cur_ctx), .valid_q(valid_q)
);

// File: tb/ctx_tlb_test.sv
module ctx_tlb_test;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wr = 0, mode_tagged = 0, base_wr = 0;
    logic [63:0] base_val = '0;
    logic        inv_ctx_req = 0;
    logic [11:0] inv_ctx_id = '0;
    logic        flush_all = 0, fill_valid = 0, fill_global = 0, lk_valid = 0;
    logic [19:0] fill_vpn = '0, fill_ppn = '0, lk_vpn = '0;
    logic        lk_done, lk_hit, tag_mode;
    logic [19:0] lk_ppn;
    logic [11:0] cur_ctx;

    always #10 clk = ~clk;

    ctx_tlb uut (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_tagged(mode_tagged),
        .base_wr(base_wr), .base_val(base_val), .inv_ctx_req(inv_ctx_req),
        .inv_ctx_id(inv_ctx_id), .flush_all(flush_all), .fill_valid(fill_valid),
        .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_global(fill_global),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_done(lk_done), .lk_hit(lk_hit),
        .lk_ppn(lk_ppn), .cur_ctx(cur_ctx), .tag_mode(tag_mode)
    );

    int checks = 0, fails = 0;

    // reference model
    logic        mv[N];
    logic [19:0] mvpn[N], mppn[N];
    logic [11:0] mtg[N];
    logic        mgl[N];
    int          mrr = 0;
    logic [11:0] mctx = '0;
    logic        mtag = 1'b0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int m_find(input logic [19:0] v);
        int r = -1;
        for (int i = N - 1; i >= 0; i--)
            if (mv[i] && mvpn[i] == v && (mgl[i] || mtg[i] == mctx)) r = i;
        return r;
    endfunction

    task automatic op_fill(input logic [19:0] v, input logic [19:0] p, input logic g);
        int k;
        @(negedge clk);
        fill_valid = 1; fill_vpn = v; fill_ppn = p; fill_global = g;
        @(negedge clk);
        fill_valid = 0; fill_global = 0;
        k = m_find(v);
        if (k < 0)
            for (int i = N - 1; i >= 0; i--) if (!mv[i]) k = i;
        if (k < 0) begin
            k = mrr;
            mrr = (mrr + 1) % N;
        end
        mv[k] = 1; mvpn[k] = v; mppn[k] = p; mtg[k] = mctx; mgl[k] = g;
    endtask

    task automatic op_base(input logic [63:0] val);
        @(negedge clk);
        base_wr = 1; base_val = val;
        @(negedge clk);
        base_wr = 0;
        if (!mtag) begin
            for (int i = 0; i < N; i++) mv[i] = 0;
        end else begin
            mctx = val[11:0];
            if (val[63])
                for (int i = 0; i < N; i++) if (!mgl[i] && mtg[i] == mctx) mv[i] = 0;
        end
    endtask

    task automatic op_inv(input logic [11:0] id);
        @(negedge clk);
        inv_ctx_req = 1; inv_ctx_id = id;
        @(negedge clk);
        inv_ctx_req = 0;
        for (int i = 0; i < N; i++) if (!mgl[i] && mtg[i] == id) mv[i] = 0;
    endtask

    task automatic op_flush();
        @(negedge clk);
        flush_all = 1;
        @(negedge clk);
        flush_all = 0;
        for (int i = 0; i < N; i++) mv[i] = 0;
    endtask

    task automatic op_mode(input logic t);
        @(negedge clk);
        mode_wr = 1; mode_tagged = t;
        @(negedge clk);
        mode_wr = 0;
        mtag = t;
        if (!t) mctx = '0;
    endtask

    task automatic lookup(input logic [19:0] v, input string req);
        int k;
        @(negedge clk);
        lk_valid = 1; lk_vpn = v;
        @(negedge clk);
        lk_valid = 0;
        k = m_find(v);
        chk({req, " done"}, 64'(lk_done), 64'd1);
        chk({req, " hit"}, 64'(lk_hit), (k >= 0) ? 64'd1 : 64'd0);
        chk({req, " ppn"}, 64'(lk_ppn), (k >= 0) ? 64'(mppn[k]) : 64'd0);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        void'($urandom(32'h5EED1));
        for (int i = 0; i < N; i++) begin
            mv[i] = 0; mvpn[i] = '0; mppn[i] = '0; mtg[i] = '0; mgl[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12 reset state
        chk("R12 reset done", 64'(lk_done), 0);
        chk("R12 reset mode", 64'(tag_mode), 0);
        chk("R12 reset ctx", 64'(cur_ctx), 0);
        lookup(20'h5, "R12 empty after reset");

        // flat mode basics
        op_fill(20'h5, 20'h55, 0);
        lookup(20'h5, "R4 flat fill hit");
        lookup(20'h6, "R1 miss");
        op_base(64'h123);
        lookup(20'h5, "R5 flat base flush");
        chk("R5 ctx stays 0", 64'(cur_ctx), 0);

        // tagged mode
        op_mode(1);
        chk("R12 mode tagged", 64'(tag_mode), 1);
        op_base(64'h7);
        chk("R6 ctx load", 64'(cur_ctx), 64'h7);
        op_fill(20'hA, 20'hAAA, 0);
        op_fill(20'h14, 20'h777, 1);
        op_base(64'h9);
        lookup(20'hA, "R2 other ctx miss");
        lookup(20'h14, "R3 global hit");
        op_base(64'h7);
        lookup(20'hA, "R6 entries kept");
        op_base(64'h8000_0000_0000_0007);
        lookup(20'hA, "R7 purge on load");
        lookup(20'h14, "R7 global kept");
        op_fill(20'hA, 20'hBBB, 0);
        op_inv(12'h7);
        lookup(20'hA, "R8 inv ctx");
        lookup(20'h14, "R8 global kept");
        op_fill(20'hA, 20'hC01, 0);
        op_fill(20'hA, 20'hC02, 0);
        lookup(20'hA, "R11 overwrite");
        op_flush();
        lookup(20'h14, "R9 global flushed");

        // R10 replacement order
        for (int i = 0; i < N; i++) op_fill(20'h100 + 20'(i), 20'h900 + 20'(i), 0);
        op_fill(20'h200, 20'hE00, 0);
        lookup(20'h100, "R10 first victim");
        lookup(20'h101, "R10 second kept");
        op_fill(20'h201, 20'hE01, 0);
        lookup(20'h101, "R10 round robin");
        lookup(20'h201, "R10 new entry");
        op_mode(0);
        chk("R12 leave tagged ctx", 64'(cur_ctx), 0);
        op_mode(1);

        // constrained random mix
        for (int n = 0; n < 4000; n++) begin
            int r = int'($urandom_range(99));
            logic [19:0] v = 20'($urandom_range(23));
            if (r < 35)      op_fill(v, 20'($urandom), 1'($urandom_range(9) == 0));
            else if (r < 75) lookup(v, "R2 R3 R10 R11 random");
            else if (r < 88) op_base({1'($urandom_range(3) == 0), 51'd0, 12'($urandom_range(3))});
            else if (r < 95) op_inv(12'($urandom_range(3)));
            else if (r < 97) op_flush();
            else             op_mode(1'($urandom_range(3) != 0));
        end
        report();
    end
endmodule